// File: doc/BRIEF.md
# Four-Point Inverse DCT Butterfly

This unit takes one vector of four signed 16-bit transform coefficients and returns the four signed 16-bit samples of a 4-point inverse discrete cosine transform. The arithmetic is fixed and must match bit for bit:

- **Even half.** Coefficients 0 and 2 are added and subtracted in 16-bit arithmetic that wraps on overflow. Each result is scaled by the Q14 constant 11585.
- **Odd half.** Coefficients 1 and 3 are rotated by the Q14 constants 6270 and 15137, with 32-bit accumulation.
- **Reduction.** Each of the four 32-bit products is rounded, shifted right by 14 and clamped to 16 bits.
- **Output butterfly.** A final wrapping add/subtract stage forms the four outputs.

The unit is one row or column pass of a larger 2-D inverse transform. The surrounding pass control feeds it vectors over a valid/ready handshake and collects results over a second valid/ready handshake. A single output register gives a latency of one cycle. While the consumer stalls, that register holds its contents and blocks new input.

Top module: `idct4_core`

## Requirements
- R1: The even-half pre-sum s = x0+x2 and pre-difference t = x0−x2 are computed modulo 2^16 as signed 16-bit values; for example, x0 = x2 = 20000 gives s = −25536.
- R2: The products are p0 = s·11585, p1 = t·11585, p2 = x1·6270 − x3·15137 and p3 = x1·15137 + x3·6270, all exact in signed 32-bit arithmetic.
- R3: Each product p is reduced as r = (p + 8192) >> 14, an arithmetic shift; for example, p = −11585 gives r = −1.
- R4: Each reduced value is clamped to [−32768, 32767]; for example, x1 = x3 = 32767 with x0 = x2 = 0 gives r3 = 32767.
- R5: The outputs are y0 = r0+r3, y1 = r1+r2, y2 = r1−r2 and y3 = r0−r3, each wrapping in 16 bits. Lane k of coef_i and res_o occupies bits [16k+15:16k].
- R6: A vector is accepted on a rising edge where in_valid_i and in_ready_o are both high. out_valid_o is high after that edge and res_o then carries the result for that vector.
- R7: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and res_o does not change on the next edge.
- R8: in_ready_o is high exactly when out_valid_o is low or out_ready_i is high, so a stalled result is never overwritten.
- R9: While rst_ni is low, and after it is released with no input accepted, out_valid_o is low and in_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input vector valid |
| in_ready_o | output | 1 | Unit can accept a vector |
| coef_i | input | 64 | Four signed coefficients, lane k at [16k+15:16k] |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Consumer takes the result |
| res_o | output | 64 | Four signed results, lane k at [16k+15:16k] |

## Verification
The bound checker watches the handshake on every cycle:

- an accepted vector always produces a valid output on the next edge;
- a valid output only appears after an acceptance;
- a stalled result keeps both its valid flag and its data;
- the unit refuses input while stalled.

The checker also watches the saturation of the largest odd-half product against its rounded lane.

The wrapping pre-sum, the rounding direction on negative products, the constant values and the lane order of the butterfly are properties of the data. Only the scenarios can show them, by comparing each result with an integer model. The scenarios use directed corner vectors and more than a thousand random ones under three backpressure patterns.

// File: rtl/idct4_pkg.sv
`timescale 1ns/1ps
package idct4_pkg;
  localparam int DATA_W = 16;
  localparam int PROD_W = 32;
  localparam int FRAC_W = 14;
  localparam int LANES  = 4;

  // Q14 cosine constants
  localparam logic signed [DATA_W-1:0] K_C8  = 16'sh3B21;
  localparam logic signed [DATA_W-1:0] K_C16 = 16'sh2D41;
  localparam logic signed [DATA_W-1:0] K_C24 = 16'sh187E;
endpackage

// File: rtl/idct4_even.sv
`timescale 1ns/1ps
module idct4_even #(
  parameter int DATA_W = idct4_pkg::DATA_W,
  parameter int PROD_W = idct4_pkg::PROD_W
) (
  input  logic signed [DATA_W-1:0] x0_i,
  input  logic signed [DATA_W-1:0] x2_i,
  output logic signed [PROD_W-1:0] p_sum_o,
  output logic signed [PROD_W-1:0] p_dif_o
);
  localparam logic signed [PROD_W-1:0] KC16 = PROD_W'(idct4_pkg::K_C16);

  logic signed [DATA_W-1:0] sum_w, dif_w;

  // wraps by width
  assign sum_w = x0_i + x2_i;
  assign dif_w = x0_i - x2_i;

  assign p_sum_o = PROD_W'(sum_w) * KC16;
  assign p_dif_o = PROD_W'(dif_w) * KC16;
endmodule

// File: rtl/idct4_odd.sv
`timescale 1ns/1ps
module idct4_odd #(
  parameter int DATA_W = idct4_pkg::DATA_W,
  parameter int PROD_W = idct4_pkg::PROD_W
) (
  input  logic signed [DATA_W-1:0] x1_i,
  input  logic signed [DATA_W-1:0] x3_i,
  output logic signed [PROD_W-1:0] p_lo_o,
  output logic signed [PROD_W-1:0] p_hi_o
);
  localparam logic signed [PROD_W-1:0] KC8  = PROD_W'(idct4_pkg::K_C8);
  localparam logic signed [PROD_W-1:0] KC24 = PROD_W'(idct4_pkg::K_C24);

  logic signed [PROD_W-1:0] x1_w, x3_w;

  assign x1_w = PROD_W'(x1_i);
  assign x3_w = PROD_W'(x3_i);

  assign p_lo_o = x1_w * KC24 - x3_w * KC8;
  assign p_hi_o = x1_w * KC8 + x3_w * KC24;
endmodule

// File: rtl/idct4_rnd_sat.sv
`timescale 1ns/1ps
module idct4_rnd_sat #(
  parameter int IN_W  = idct4_pkg::PROD_W,
  parameter int OUT_W = idct4_pkg::DATA_W,
  parameter int SHIFT = idct4_pkg::FRAC_W
) (
  input  logic signed [IN_W-1:0]  prod_i,
  output logic signed [OUT_W-1:0] val_o
);
  localparam int SW = IN_W + 1;
  localparam logic signed [SW-1:0] HALF  = SW'(1 << (SHIFT - 1));
  localparam logic signed [SW-1:0] MAX_V = SW'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [SW-1:0] MIN_V = -MAX_V - SW'(1);

  logic signed [SW-1:0] sum_w, shr_w;

  // one guard bit keeps the rounding add exact
  assign sum_w = SW'(prod_i) + HALF;
  assign shr_w = sum_w >>> SHIFT;

  always_comb begin
    if (shr_w > MAX_V)      val_o = MAX_V[OUT_W-1:0];
    else if (shr_w < MIN_V) val_o = MIN_V[OUT_W-1:0];
    else                    val_o = shr_w[OUT_W-1:0];
  end
endmodule

// File: rtl/idct4_bfly.sv
`timescale 1ns/1ps
module idct4_bfly #(
  parameter int DATA_W = idct4_pkg::DATA_W
) (
  input  logic signed [DATA_W-1:0] r_sum_i,
  input  logic signed [DATA_W-1:0] r_dif_i,
  input  logic signed [DATA_W-1:0] r_lo_i,
  input  logic signed [DATA_W-1:0] r_hi_i,
  output logic signed [DATA_W-1:0] y0_o,
  output logic signed [DATA_W-1:0] y1_o,
  output logic signed [DATA_W-1:0] y2_o,
  output logic signed [DATA_W-1:0] y3_o
);
  assign y0_o = r_sum_i + r_hi_i;
  assign y1_o = r_dif_i + r_lo_i;
  assign y2_o = r_dif_i - r_lo_i;
  assign y3_o = r_sum_i - r_hi_i;
endmodule

// File: rtl/idct4_core.sv
`timescale 1ns/1ps
module idct4_core #(
  parameter int DATA_W = idct4_pkg::DATA_W,
  parameter int PROD_W = idct4_pkg::PROD_W,
  parameter int FRAC_W = idct4_pkg::FRAC_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  in_valid_i,
  output logic                  in_ready_o,
  input  logic [4*DATA_W-1:0]   coef_i,
  output logic                  out_valid_o,
  input  logic                  out_ready_i,
  output logic [4*DATA_W-1:0]   res_o
);
  localparam int LANES = idct4_pkg::LANES;
  localparam int VEC_W = LANES * DATA_W;

  logic signed [DATA_W-1:0] x_w [LANES];
  logic signed [PROD_W-1:0] prod_w [LANES];
  logic signed [DATA_W-1:0] rnd_w [LANES];
  logic signed [DATA_W-1:0] y_w [LANES];
  logic [VEC_W-1:0]         y_vec_w;

  logic             valid_q;
  logic [VEC_W-1:0] data_q;
  logic             accept_w;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign x_w[k] = coef_i[k*DATA_W +: DATA_W];
    assign y_vec_w[k*DATA_W +: DATA_W] = y_w[k];

    idct4_rnd_sat #(
      .IN_W (PROD_W),
      .OUT_W(DATA_W),
      .SHIFT(FRAC_W)
    ) u_rnd (
      .prod_i(prod_w[k]),
      .val_o (rnd_w[k])
    );
  end

  idct4_even #(.DATA_W(DATA_W), .PROD_W(PROD_W)) u_even (
    .x0_i   (x_w[0]),
    .x2_i   (x_w[2]),
    .p_sum_o(prod_w[0]),
    .p_dif_o(prod_w[1])
  );

  idct4_odd #(.DATA_W(DATA_W), .PROD_W(PROD_W)) u_odd (
    .x1_i  (x_w[1]),
    .x3_i  (x_w[3]),
    .p_lo_o(prod_w[2]),
    .p_hi_o(prod_w[3])
  );

  idct4_bfly #(.DATA_W(DATA_W)) u_bfly (
    .r_sum_i(rnd_w[0]),
    .r_dif_i(rnd_w[1]),
    .r_lo_i (rnd_w[2]),
    .r_hi_i (rnd_w[3]),
    .y0_o   (y_w[0]),
    .y1_o   (y_w[1]),
    .y2_o   (y_w[2]),
    .y3_o   (y_w[3])
  );

  // output slot frees when empty or drained this edge
  assign in_ready_o = !valid_q || out_ready_i;
  assign accept_w   = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      if (in_ready_o) valid_q <= in_valid_i;
      if (accept_w)   data_q  <= y_vec_w;
    end
  end

  assign out_valid_o = valid_q;
  assign res_o       = data_q;
endmodule

// File: rtl/idct4_core_chk.sv
`timescale 1ns/1ps
module idct4_core_chk #(
  parameter int DATA_W = 16,
  parameter int PROD_W = 32
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     in_valid_i,
  input logic                     in_ready_o,
  input logic                     out_valid_o,
  input logic                     out_ready_i,
  input logic [4*DATA_W-1:0]      res_o,
  input logic signed [PROD_W-1:0] prod_hi,
  input logic signed [DATA_W-1:0] rnd_hi
);
  localparam logic signed [PROD_W-1:0] SAT_POS = PROD_W'(536862720);
  localparam logic signed [PROD_W-1:0] SAT_NEG = -PROD_W'(536879104);

  // R6
  accept_to_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o);

  // R6
  valid_needs_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> $past(in_valid_i && in_ready_o));

  // R7
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(res_o));

  // R8
  stall_blocks_input_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o);

  // R4
  sat_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prod_hi >= SAT_POS |-> rnd_hi == 16'sh7FFF);

  // R4
  sat_neg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prod_hi < SAT_NEG |-> rnd_hi == -16'sh8000);

  // R9
  always @(posedge clk_i) begin
    if (!rst_ni) reset_idle_chk: assert (!out_valid_o && in_ready_o);
  end
endmodule

bind idct4_core idct4_core_chk #(.DATA_W(DATA_W), .PROD_W(PROD_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i),
  .res_o      (res_o),
  .prod_hi    (prod_w[3]),
  .rnd_hi     (rnd_w[3])
);

// File: tb/sim_idct4_core.sv
`timescale 1ns/1ps
module sim_idct4_core;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [63:0] coef_i = '0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b1;
  logic [63:0] res_o;

  int n_cmp = 0;
  int n_bad = 0;
  int bp_mode = 0;
  bit done = 1'b0;

  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #10 clk_i = ~clk_i;

  idct4_core u0 (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .coef_i     (coef_i),
    .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i),
    .res_o      (res_o)
  );

  function automatic shortint reduce(int p);
    int t;
    t = (p + 8192) >>> 14;
    if (t > 32767) t = 32767;
    if (t < -32768) t = -32768;
    return shortint'(t);
  endfunction

  function automatic logic [63:0] model(logic [63:0] v);
    shortint x0, x1, x2, x3, s, t, r0, r1, r2, r3, y0, y1, y2, y3;
    x0 = v[15:0]; x1 = v[31:16]; x2 = v[47:32]; x3 = v[63:48];
    s = x0 + x2;
    t = x0 - x2;
    r0 = reduce(int'(s) * 11585);
    r1 = reduce(int'(t) * 11585);
    r2 = reduce(int'(x1) * 6270 - int'(x3) * 15137);
    r3 = reduce(int'(x1) * 15137 + int'(x3) * 6270);
    y0 = r0 + r3; y1 = r1 + r2; y2 = r1 - r2; y3 = r0 - r3;
    return {y3, y2, y1, y0};
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(logic [63:0] v, string tag);
    @(negedge clk_i);
    coef_i = v;
    in_valid_i = 1'b1;
    exp_q.push_back(model(v));
    tag_q.push_back(tag);
    #1;
    while (!in_ready_o) begin
      @(negedge clk_i);
      #1;
    end
    @(posedge clk_i);
    #1;
    in_valid_i = 1'b0;
    @(negedge clk_i);
    #3;
    // R6: valid follows acceptance by one edge
    check(out_valid_o === 1'b1, "R6 valid after accept", 64'(out_valid_o), 64'd1);
  endtask

  // consumer backpressure
  initial begin
    forever begin
      @(negedge clk_i);
      case (bp_mode)
        0: out_ready_i <= 1'b1;
        1: out_ready_i <= ($urandom_range(1) == 0);
        default: out_ready_i <= ($urandom_range(3) == 0);
      endcase
    end
  end

  // monitor / scoreboard
  initial begin
    logic [63:0] held = '0;
    bit held_v = 1'b0;
    forever begin
      @(negedge clk_i);
      #2;
      if (rst_ni) begin
        // R8
        check(in_ready_o === (!out_valid_o || out_ready_i), "R8 ready rule",
              64'(in_ready_o), 64'(!out_valid_o || out_ready_i));
        if (held_v) begin
          // R7
          check(out_valid_o === 1'b1 && res_o === held, "R7 stall hold", res_o, held);
        end
        held_v = 1'b0;
        if (out_valid_o && !out_ready_i) begin
          held = res_o;
          held_v = 1'b1;
        end else if (out_valid_o && out_ready_i) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R6 unexpected output", res_o, 64'd0);
          end else begin
            logic [63:0] e;
            string tg;
            e = exp_q.pop_front();
            tg = tag_q.pop_front();
            check(res_o === e, tg, res_o, e);
          end
        end
      end
    end
  end

  initial begin
    #4_000_000;
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #2;
    // R9
    check(out_valid_o === 1'b0 && in_ready_o === 1'b1, "R9 in reset",
          {62'd0, out_valid_o, in_ready_o}, 64'd1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #2;
    // R9
    check(out_valid_o === 1'b0 && in_ready_o === 1'b1, "R9 after release",
          {62'd0, out_valid_o, in_ready_o}, 64'd1);

    send(64'h0, "R2 R5 zeros");
    send({4{16'h8000}}, "R1 R4 all min");
    send({4{16'h7FFF}}, "R4 all max");
    send({16'd0, 16'd0, 16'd20000, 16'd20000}, "R1 wrap sum");
    send({16'h0, 16'hB1E0, 16'h0, 16'd20000}, "R1 wrap diff");
    send({16'h7FFF, 16'h0, 16'h7FFF, 16'h0}, "R4 sat pos");
    send({16'h8000, 16'h0, 16'h8000, 16'h0}, "R4 sat neg");
    send({16'h0, 16'h0, 16'h0, 16'd1}, "R3 round pos");
    send({16'h0, 16'h0, 16'h0, 16'hFFFF}, "R3 round neg");
    send({16'h0, 16'h0, 16'd1000, 16'h0}, "R5 lane x1");
    send({16'd1000, 16'h0, 16'h0, 16'h0}, "R5 lane x3");
    send({16'h0, 16'd1000, 16'h0, 16'h0}, "R2 lane x2");

    for (int m = 0; m < 3; m++) begin
      bp_mode = m;
      for (int i = 0; i < 350; i++) begin
        send({$urandom(), $urandom()}, "R2 R3 R5 random");
      end
    end

    bp_mode = 0;
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk_i);
    #5;
    check(exp_q.size() == 0, "R6 all drained", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule